// File: doc/BRIEF.md
# Grouped Carry Look-Ahead Adder

This block is the binary adder at the core of a small processor's arithmetic unit. It adds two unsigned operand words and a single incoming carry, and returns the sum word and the carry out of the top bit. The block is purely combinational. Results follow the inputs in the same time step, with no clock and no state.

The operand bits are split into groups of four. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set, inclusive OR). Inside a group, every carry is produced from these terms and the group's incoming carry by one flat sum-of-products. No carry ripples from bit to bit. Each group also reports a group generate and a group propagate.

A second look-ahead level applies the same equations to those group terms, and so gives every group its incoming carry straight from the input carry. One level serves four groups, which is 16 bits. Wider words chain these 16-bit blocks. No AND or OR term anywhere in the carry logic takes more than five inputs.

Top module: `cla_adder`

## Requirements
- R1: Each sum bit s_o[i] equals the odd parity of x_i[i], y_i[i] and the carry into bit i. The carry into bit 0 is cin_i.
- R2: For every operand pair and input carry, the concatenation {cout_o, s_o} equals x_i + y_i + cin_i, taken as a WIDTH+1 bit unsigned value.
- R3: A bit whose two operand bits are both 1 sends a carry into the next bit, whatever its own incoming carry is. For example, x_i=0x0001 and y_i=0x0001 give s_o bit 1 = 1 for both values of cin_i.
- R4: A bit with exactly one operand bit set passes its incoming carry through unchanged. For example, x_i=0x0001, y_i=0 and cin_i=1 give s_o=0x0002.
- R5: A 4-bit group whose group generate is 1 forces a carry into the next group, independent of the group's incoming carry. For example, x_i=0x000F, y_i=0x0001 and cin_i=0 give s_o=0x0010.
- R6: A group whose four propagate terms are all 1 and whose group generate is 0 passes its incoming carry to the next group. For example, x_i=0xFFFF, y_i=0 and cin_i=1 give s_o=0 and cout_o=1.
- R7: cout_o is the carry out of the most significant group. Adding all-ones to all-ones with cin_i=1 gives s_o=0xFFFF and cout_o=1.
- R8: WIDTH must be a multiple of 4, and any other value stops elaboration. At WIDTH=4 the single group alone produces a correct sum for all 512 input combinations.
- R9: The outputs hold no state. They depend only on the present inputs, and a new input set is reflected within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Incoming carry into bit 0 |
| s_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
A wrong generate, propagate or group term has no hidden state to sit in. It shows at once as a wrong sum bit or a wrong carry-out for any input that exercises that term. The observation window is therefore the same time step as the stimulus.

The faults that are hardest to expose are those in the high-order product terms, such as the five-input term that carries cin_i through a fully propagating group, or a group-to-group link. Only long propagate runs reach these terms. The bench therefore combines an exhaustive sweep of a single group with directed carry-chain words that cross every group boundary, and adds random operands on top.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_BITS    = 4;  // bits per look-ahead group
  localparam int unsigned GRP_PER_BLK = 4;  // groups joined by one block level
  localparam int unsigned MAX_FANIN   = 5;
endpackage

// File: rtl/cla_lah4.sv
// Flat 4-stage look-ahead: each carry is one OR of at most 5 AND terms of at most 5 inputs.
module cla_lah4 (
  input  logic [3:0] g_i,
  input  logic [3:0] p_i,
  input  logic       c_i,
  output logic [3:0] c_o
);
  always_comb begin
    c_o[0] = g_i[0]
           | (p_i[0] & c_i);
    c_o[1] = g_i[1]
           | (p_i[1] & g_i[0])
           | (p_i[1] & p_i[0] & c_i);
    c_o[2] = g_i[2]
           | (p_i[2] & g_i[1])
           | (p_i[2] & p_i[1] & g_i[0])
           | (p_i[2] & p_i[1] & p_i[0] & c_i);
    c_o[3] = g_i[3]
           | (p_i[3] & g_i[2])
           | (p_i[3] & p_i[2] & g_i[1])
           | (p_i[3] & p_i[2] & p_i[1] & g_i[0])
           | (p_i[3] & p_i[2] & p_i[1] & p_i[0] & c_i);
  end
endmodule

// File: rtl/cla_group4.sv
module cla_group4 (
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       gg_o,
  output logic       gp_o
);
  logic [3:0] g, p, c_out;
  logic [3:0] c_in;

  assign g = x_i & y_i;
  assign p = x_i | y_i;  // inclusive OR propagate

  cla_lah4 i_lah (
    .g_i(g),
    .p_i(p),
    .c_i(c_i),
    .c_o(c_out)
  );

  assign c_in = {c_out[2:0], c_i};
  assign s_o  = x_i ^ y_i ^ c_in;

  assign gg_o = g[3]
              | (p[3] & g[2])
              | (p[3] & p[2] & g[1])
              | (p[3] & p[2] & p[1] & g[0]);
  assign gp_o = &p;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o,
  output logic             cout_o
);
  import cla_pkg::*;

  localparam int unsigned NG = WIDTH / GRP_BITS;
  localparam int unsigned NB = (NG + GRP_PER_BLK - 1) / GRP_PER_BLK;

  if ((WIDTH % GRP_BITS) != 0 || WIDTH == 0) begin : g_bad_width
    $error("cla_adder: WIDTH must be a non-zero multiple of 4 (R8)");
  end

  logic [NG-1:0] gg, gp;
  logic [NG:0]   gc;  // gc[k] = carry into group k

  assign gc[0] = cin_i;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_group4 i_grp (
      .x_i (x_i[GRP_BITS*k +: GRP_BITS]),
      .y_i (y_i[GRP_BITS*k +: GRP_BITS]),
      .c_i (gc[k]),
      .s_o (s_o[GRP_BITS*k +: GRP_BITS]),
      .gg_o(gg[k]),
      .gp_o(gp[k])
    );
  end

  // Block level: 4 groups per block; blocks chain when WIDTH > 16.
  for (genvar b = 0; b < NB; b++) begin : g_blk
    logic [3:0] bg, bp, bc;
    for (genvar k = 0; k < GRP_PER_BLK; k++) begin : g_pad
      if (GRP_PER_BLK*b + k < NG) begin : g_live
        assign bg[k] = gg[GRP_PER_BLK*b + k];
        assign bp[k] = gp[GRP_PER_BLK*b + k];
        assign gc[GRP_PER_BLK*b + k + 1] = bc[k];
      end else begin : g_unused
        assign bg[k] = 1'b0;
        assign bp[k] = 1'b0;
      end
    end
    cla_lah4 i_blk_lah (
      .g_i(bg),
      .p_i(bp),
      .c_i(gc[GRP_PER_BLK*b]),
      .c_o(bc)
    );
  end

  assign cout_o = gc[NG];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NG    = WIDTH / 4
) (
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] s_o,
  input logic             cout_o,
  input logic [NG-1:0]    gg,
  input logic [NG-1:0]    gp,
  input logic [NG:0]      gc
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    p_lsb_parity_r1: assert (s_o[0] == (x_i[0] ^ y_i[0] ^ cin_i))
      else $error("R1 lsb parity");
    p_total_r2: assert ({cout_o, s_o} == ref_sum)
      else $error("R2 sum mismatch");
    p_cout_r7: assert (cout_o == gc[NG])
      else $error("R7 cout link");
    for (int k = 0; k < NG; k++) begin
      p_grp_gen_r5: assert (!gg[k] || gc[k+1])
        else $error("R5 group generate");
      p_grp_prop_r6: assert (!(gp[k] && !gg[k]) || (gc[k+1] == gc[k]))
        else $error("R6 group propagate");
      p_grp_kill_r6: assert (gp[k] || gg[k] || !gc[k+1])
        else $error("R6 group kill");
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH), .NG(WIDTH/4)) i_cla_adder_chk (
  .x_i   (x_i),
  .y_i   (y_i),
  .cin_i (cin_i),
  .s_o   (s_o),
  .cout_o(cout_o),
  .gg    (gg),
  .gp    (gp),
  .gc    (gc)
);

// File: tb/test_cla_adder.sv
`timescale 1ns/1ps
module test_cla_adder;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0] x, y, s;
  logic         cin, cout;
  logic [3:0]   x4, y4, s4;
  logic         cin4, cout4;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  cla_adder #(.WIDTH(W)) i_cla_adder (
    .x_i(x), .y_i(y), .cin_i(cin), .s_o(s), .cout_o(cout)
  );
  cla_adder #(.WIDTH(4)) i_cla_adder_n4 (
    .x_i(x4), .y_i(y4), .cin_i(cin4), .s_o(s4), .cout_o(cout4)
  );

  task automatic check_val(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at posedge, sample at the following negedge
  task automatic apply16(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c);
    logic [W:0] exp;
    @(posedge clk);
    x = a; y = b; cin = c;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    check_val(req, {cout, s}, exp);
  endtask

  task automatic t_idle_state;  // R9: zero inputs give zero outputs
    apply16("R9 idle", '0, '0, 1'b0);
  endtask

  task automatic t_same_step;  // R9: result visible 1 ns after change
    @(posedge clk);
    x = 16'h1234; y = 16'h4321; cin = 1'b1;
    #1;
    check_val("R9 same step", {cout, s}, 17'h05556);
  endtask

  task automatic t_exhaustive_n4;  // R8
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          logic [4:0] e;
          @(posedge clk);
          x4 = a[3:0]; y4 = b[3:0]; cin4 = c[0];
          e = 5'(a) + 5'(b) + 5'(c);
          @(negedge clk);
          check_val("R8 n4 exhaustive", {12'b0, cout4, s4}, {12'b0, e});
        end
  endtask

  task automatic t_parity_r1;
    for (int i = 0; i < W; i++) begin
      apply16("R1 single bit", W'(1) << i, '0, 1'b1);
      apply16("R1 two ones",   W'(1) << i, W'(1) << i, 1'b0);
    end
  endtask

  task automatic t_generate_r3;
    apply16("R3 gen cin0", 16'h0001, 16'h0001, 1'b0);
    apply16("R3 gen cin1", 16'h0001, 16'h0001, 1'b1);
    apply16("R3 gen mid",  16'h0100, 16'h0100, 1'b0);
  endtask

  task automatic t_propagate_r4;
    apply16("R4 prop x", 16'h0001, 16'h0000, 1'b1);
    apply16("R4 prop y", 16'h0000, 16'h0007, 1'b1);
    apply16("R4 prop mix", 16'h0005, 16'h000A, 1'b1);
  endtask

  task automatic t_group_gen_r5;
    apply16("R5 grp0 gen", 16'h000F, 16'h0001, 1'b0);
    apply16("R5 grp1 gen", 16'h00F0, 16'h0010, 1'b0);
    apply16("R5 grp2 gen", 16'h0800, 16'h0800, 1'b1);
    apply16("R5 top gen",  16'h8000, 16'h8000, 1'b0);
  endtask

  task automatic t_group_prop_r6;
    apply16("R6 full chain", 16'hFFFF, 16'h0000, 1'b1);
    apply16("R6 no carry",   16'hFFFF, 16'h0000, 1'b0);
    apply16("R6 alt chain",  16'hAAAA, 16'h5555, 1'b1);
    apply16("R6 cross grp",  16'h0FFF, 16'h0000, 1'b1);
    apply16("R6 gen into chain", 16'hFFF1, 16'h000F, 1'b0);
  endtask

  task automatic t_cout_r7;
    apply16("R7 all ones cin1", 16'hFFFF, 16'hFFFF, 1'b1);
    apply16("R7 all ones cin0", 16'hFFFF, 16'hFFFF, 1'b0);
    apply16("R7 no cout",       16'h7FFF, 16'h7FFF, 1'b1);
  endtask

  task automatic t_random_r2;
    for (int i = 0; i < 3000; i++)
      apply16("R2 random", W'($urandom), W'($urandom), 1'($urandom));
  endtask

  initial begin
    x = '0; y = '0; cin = 1'b0;
    x4 = '0; y4 = '0; cin4 = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle_state();
    t_same_step();
    t_exhaustive_n4();
    t_parity_r1();
    t_generate_r3();
    t_propagate_r4();
    t_group_gen_r5();
    t_group_prop_r6();
    t_cout_r7();
    t_random_r2();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule